// File: doc/BRIEF.md
# Out-of-Order Divider Reorder Buffer

This block takes dividend/divisor pairs from an in-order dispatch port and runs them on a pool of parallel multi-cycle dividers. Each divider's latency depends on its operands, so results finish out of order. A circular reorder buffer gives each accepted pair a tag, which is the low bits of its write pointer at acceptance. The pair waits in its entry until a divider is free. The entry then records the quotient and remainder when that divider reports completion. Results leave through the graduation output strictly in the order they were accepted.

The buffer has more entries than there are dividers. Pairs can therefore queue in the buffer while every divider is busy. The issue logic always hands the oldest waiting pair to the lowest-numbered idle divider, one pair per cycle. Dispatch stalls only when every entry is occupied.

Top module: `ooo_div_rob`

## Requirements
- R1: After reset `disp_ready` is 1, `grad_valid` is 0 and `disp_tag` is 0.
- R2: `disp_tag` shows the tag given to the next accepted pair. Tags are handed out as 0,1,2,…,7,0,… in acceptance order. After 32 accepted pairs the tag is back at 0.
- R3: `disp_ready` is 0 exactly when 8 accepted pairs have not yet graduated. A `disp_valid` presented while `disp_ready` is 0 creates no entry and produces no graduation.
- R4: For a nonzero divisor b and dividend a, the graduated quotient is floor(a/b) and the remainder is a mod b, both unsigned and 8 bits wide.
- R5: Every accepted pair graduates exactly once, in acceptance order, with `grad_tag` equal to the tag it was given. `grad_valid` is never 1 while the buffer is empty, and at most one pair graduates per cycle.
- R6: Four dividers run concurrently. A divider takes 1 + (bit length of the quotient) cycles, so later pairs may finish first. More than four pairs can be outstanding at once.
- R7: For divisor 0, the quotient is all ones (8'hFF) and the remainder equals the dividend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | A pair is offered for dispatch |
| disp_dividend | input | 8 | Dividend of the offered pair |
| disp_divisor | input | 8 | Divisor of the offered pair |
| disp_ready | output | 1 | Buffer has a free entry; the offered pair is taken this cycle |
| disp_tag | output | 3 | Tag the next accepted pair receives |
| grad_valid | output | 1 | A result graduates this cycle |
| grad_tag | output | 3 | Tag of the graduating pair |
| grad_quotient | output | 8 | Quotient of the graduating pair |
| grad_remainder | output | 8 | Remainder of the graduating pair |

## Verification
A stream of 32 pairs with short, mixed latencies checks tag wrap-around and the return to tag 0 (R2). A long-latency pair placed ahead of many quick ones forces the buffer to fill, which shows whether dispatch stalls at exactly eight outstanding pairs. This stream also checks that later pairs finishing first are held back until the older one graduates. A short stream alternating slow and fast divisions, including division by zero, checks that each result is written to the entry named by its tag. Finally, a sweep of every dividend against eight divisors (0, 1, 2, 3, 5, 16, 100, 255) compares each graduated value with arithmetic done in the bench. This sweep covers the whole range of latencies and completion orders.

// File: rtl/ooo_rob_pkg.sv
`timescale 1ns/1ps
package ooo_rob_pkg;
  // Lifecycle of one reorder-buffer entry
  typedef enum logic [1:0] {
    ENT_FREE = 2'd0,
    ENT_WAIT = 2'd1,
    ENT_EXEC = 2'd2,
    ENT_DONE = 2'd3
  } ent_state_e;
endpackage

// File: rtl/div_unit.sv
`timescale 1ns/1ps
// Behavioural multi-cycle divider with operand-dependent latency.
module div_unit #(
  parameter int DATA_W = 8,
  parameter int TAG_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [TAG_W-1:0]  start_tag,
  input  logic [DATA_W-1:0] dividend,
  input  logic [DATA_W-1:0] divisor,
  output logic              busy,
  output logic              done,
  output logic [TAG_W-1:0]  done_tag,
  output logic [DATA_W-1:0] done_q,
  output logic [DATA_W-1:0] done_r
);
  localparam int CNT_W = $clog2(DATA_W + 2);

  logic              busy_q, busy_nx;
  logic [CNT_W-1:0]  cnt_q, cnt_nx;
  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0] quo_q, rem_q;

  logic              div_zero;
  logic [DATA_W-1:0] safe_div, quo_c, rem_c;
  logic [CNT_W-1:0]  lat_c;

  function automatic logic [CNT_W-1:0] bit_len(input logic [DATA_W-1:0] v);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (v[i]) n = CNT_W'(i + 1);
    end
    return n;
  endfunction

  always_comb begin
    div_zero = (divisor == '0);
    safe_div = div_zero ? DATA_W'(1) : divisor;
    quo_c    = div_zero ? '1 : dividend / safe_div;
    rem_c    = div_zero ? dividend : dividend % safe_div;
    lat_c    = div_zero ? CNT_W'(1) : CNT_W'(1) + bit_len(quo_c);
  end

  assign done     = busy_q && (cnt_q == CNT_W'(1));
  assign busy     = busy_q;
  assign done_tag = tag_q;
  assign done_q   = quo_q;
  assign done_r   = rem_q;

  // next-state
  always_comb begin
    busy_nx = busy_q;
    cnt_nx  = cnt_q;
    if (start) begin
      busy_nx = 1'b1;
      cnt_nx  = lat_c;
    end else if (done) begin
      busy_nx = 1'b0;
    end else if (busy_q) begin
      cnt_nx  = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_nx;
      cnt_q  <= cnt_nx;
    end
  end

  // payload captured with clock enable, no reset needed
  always_ff @(posedge clk) begin
    if (start) begin
      tag_q <= start_tag;
      quo_q <= quo_c;
      rem_q <= rem_c;
    end
  end

  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q) else $error("start on busy divider"); // R6
endmodule

// File: rtl/issue_sel.sv
`timescale 1ns/1ps
// Picks the oldest waiting entry and the lowest-numbered idle divider.
module issue_sel #(
  parameter int DEPTH   = 8,
  parameter int NUM_DIV = 4,
  localparam int TAG_W  = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]   ent_wait,
  input  logic [TAG_W-1:0]   head_tag,
  input  logic [NUM_DIV-1:0] div_busy,
  output logic               issue_valid,
  output logic [TAG_W-1:0]   issue_tag,
  output logic [NUM_DIV-1:0] div_start
);
  logic             ent_found, div_found;
  logic [TAG_W-1:0] idx;
  logic [NUM_DIV-1:0] free_pick;

  always_comb begin
    ent_found = 1'b0;
    issue_tag = '0;
    idx       = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head_tag + TAG_W'(k);
      if (!ent_found && ent_wait[idx]) begin
        ent_found = 1'b1;
        issue_tag = idx;
      end
    end
  end

  always_comb begin
    div_found = 1'b0;
    free_pick = '0;
    for (int d = 0; d < NUM_DIV; d++) begin
      if (!div_found && !div_busy[d]) begin
        div_found    = 1'b1;
        free_pick[d] = 1'b1;
      end
    end
  end

  assign issue_valid = ent_found && div_found;
  assign div_start   = issue_valid ? free_pick : '0;
endmodule

// File: rtl/rob_store.sv
`timescale 1ns/1ps
// Circular entry store: dispatch, issue marking, completion capture, graduation.
module rob_store
  import ooo_rob_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int DATA_W  = 8,
  parameter int NUM_DIV = 4,
  localparam int TAG_W  = $clog2(DEPTH),
  localparam int PTR_W  = TAG_W + 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           disp_fire,
  input  logic [DATA_W-1:0]              disp_a,
  input  logic [DATA_W-1:0]              disp_b,
  output logic                           full,
  output logic [TAG_W-1:0]               wr_tag,
  input  logic                           issue_valid,
  input  logic [TAG_W-1:0]               issue_tag,
  output logic [DATA_W-1:0]              iss_a,
  output logic [DATA_W-1:0]              iss_b,
  input  logic [NUM_DIV-1:0]             comp_valid,
  input  logic [NUM_DIV-1:0][TAG_W-1:0]  comp_tag,
  input  logic [NUM_DIV-1:0][DATA_W-1:0] comp_q,
  input  logic [NUM_DIV-1:0][DATA_W-1:0] comp_r,
  output logic [DEPTH-1:0]               ent_wait,
  output logic                           head_done,
  output logic [TAG_W-1:0]               head_tag,
  output logic [DATA_W-1:0]              head_q,
  output logic [DATA_W-1:0]              head_r
);
  ent_state_e        state_q [DEPTH];
  ent_state_e        state_nx [DEPTH];
  logic [PTR_W-1:0]  wp_q, wp_nx, rp_q, rp_nx;
  logic [PTR_W-1:0]  occ;
  logic [DATA_W-1:0] opa_q [DEPTH];
  logic [DATA_W-1:0] opb_q [DEPTH];
  logic [DATA_W-1:0] resq_q [DEPTH];
  logic [DATA_W-1:0] resr_q [DEPTH];

  assign wr_tag    = wp_q[TAG_W-1:0];
  assign head_tag  = rp_q[TAG_W-1:0];
  assign occ       = wp_q - rp_q;
  assign full      = (wp_q[TAG_W] != rp_q[TAG_W]) && (wr_tag == head_tag);
  assign head_done = (state_q[head_tag] == ENT_DONE);
  assign head_q    = resq_q[head_tag];
  assign head_r    = resr_q[head_tag];
  assign iss_a     = opa_q[issue_tag];
  assign iss_b     = opb_q[issue_tag];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) ent_wait[i] = (state_q[i] == ENT_WAIT);
  end

  // next-state
  always_comb begin
    for (int i = 0; i < DEPTH; i++) state_nx[i] = state_q[i];
    wp_nx = wp_q;
    rp_nx = rp_q;
    if (disp_fire) begin
      state_nx[wr_tag] = ENT_WAIT;
      wp_nx            = wp_q + PTR_W'(1);
    end
    if (issue_valid) state_nx[issue_tag] = ENT_EXEC;
    for (int d = 0; d < NUM_DIV; d++) begin
      if (comp_valid[d]) state_nx[comp_tag[d]] = ENT_DONE;
    end
    if (head_done) begin
      state_nx[head_tag] = ENT_FREE;
      rp_nx              = rp_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) state_q[i] <= ENT_FREE;
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) state_q[i] <= state_nx[i];
      wp_q <= wp_nx;
      rp_q <= rp_nx;
    end
  end

  // payload storage, written under explicit enables
  always_ff @(posedge clk) begin
    if (disp_fire) begin
      opa_q[wr_tag] <= disp_a;
      opb_q[wr_tag] <= disp_b;
    end
    for (int d = 0; d < NUM_DIV; d++) begin
      if (comp_valid[d]) begin
        resq_q[comp_tag[d]] <= comp_q[d];
        resr_q[comp_tag[d]] <= comp_r[d];
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= PTR_W'(DEPTH)) else $error("occupancy above depth"); // R3
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> $stable(wp_q)) else $error("write pointer moved while full"); // R3
  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_q == rp_q) |-> !head_done) else $error("graduation from empty buffer"); // R5
  AST_ISSUE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (state_q[issue_tag] == ENT_WAIT)) else $error("issue of non-waiting entry"); // R6

  for (genvar d = 0; d < NUM_DIV; d++) begin : g_comp_chk
    AST_COMP_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
      comp_valid[d] |-> (state_q[comp_tag[d]] == ENT_EXEC)) else $error("completion to idle entry"); // R6
  end
endmodule

// File: rtl/ooo_div_rob.sv
`timescale 1ns/1ps
module ooo_div_rob #(
  parameter int DATA_W  = 8,
  parameter int DEPTH   = 8,
  parameter int NUM_DIV = 4,
  localparam int TAG_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_valid,
  input  logic [DATA_W-1:0] disp_dividend,
  input  logic [DATA_W-1:0] disp_divisor,
  output logic              disp_ready,
  output logic [TAG_W-1:0]  disp_tag,
  output logic              grad_valid,
  output logic [TAG_W-1:0]  grad_tag,
  output logic [DATA_W-1:0] grad_quotient,
  output logic [DATA_W-1:0] grad_remainder
);
  logic                           full, disp_fire;
  logic                           issue_valid;
  logic [TAG_W-1:0]               issue_tag;
  logic [DATA_W-1:0]              iss_a, iss_b;
  logic [DEPTH-1:0]               ent_wait;
  logic [NUM_DIV-1:0]             div_busy, div_start, div_done;
  logic [NUM_DIV-1:0][TAG_W-1:0]  done_tag;
  logic [NUM_DIV-1:0][DATA_W-1:0] done_q, done_r;

  assign disp_ready = !full;
  assign disp_fire  = disp_valid && disp_ready;

  rob_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .NUM_DIV(NUM_DIV)) store_i (
    .clk(clk), .rst_n(rst_n),
    .disp_fire(disp_fire), .disp_a(disp_dividend), .disp_b(disp_divisor),
    .full(full), .wr_tag(disp_tag),
    .issue_valid(issue_valid), .issue_tag(issue_tag),
    .iss_a(iss_a), .iss_b(iss_b),
    .comp_valid(div_done), .comp_tag(done_tag), .comp_q(done_q), .comp_r(done_r),
    .ent_wait(ent_wait),
    .head_done(grad_valid), .head_tag(grad_tag),
    .head_q(grad_quotient), .head_r(grad_remainder)
  );

  issue_sel #(.DEPTH(DEPTH), .NUM_DIV(NUM_DIV)) sel_i (
    .ent_wait(ent_wait), .head_tag(grad_tag), .div_busy(div_busy),
    .issue_valid(issue_valid), .issue_tag(issue_tag), .div_start(div_start)
  );

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
    div_unit #(.DATA_W(DATA_W), .TAG_W(TAG_W)) div_i (
      .clk(clk), .rst_n(rst_n),
      .start(div_start[g]), .start_tag(issue_tag),
      .dividend(iss_a), .divisor(iss_b),
      .busy(div_busy[g]), .done(div_done[g]),
      .done_tag(done_tag[g]), .done_q(done_q[g]), .done_r(done_r[g])
    );
  end

  AST_ONE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(div_start)) else $error("more than one divider started"); // R6
  AST_ISSUE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(div_start & div_busy)) == 1'b0) else $error("busy divider selected"); // R6
endmodule

// File: tb/ooo_div_rob_tb_top.sv
`timescale 1ns/1ps
module ooo_div_rob_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       disp_valid;
  logic [7:0] disp_dividend, disp_divisor;
  logic       disp_ready;
  logic [2:0] disp_tag;
  logic       grad_valid;
  logic [2:0] grad_tag;
  logic [7:0] grad_quotient, grad_remainder;

  int n_chk = 0;
  int n_err = 0;
  int head_i = 0;
  int tail_i = 0;
  int outstanding = 0;
  int max_out = 0;
  bit saw_full = 0;
  int cyc = 0;
  logic [7:0] exp_a [4096];
  logic [7:0] exp_b [4096];

  always #10 clk = ~clk;

  ooo_div_rob dut_i (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_dividend(disp_dividend), .disp_divisor(disp_divisor),
    .disp_ready(disp_ready), .disp_tag(disp_tag),
    .grad_valid(grad_valid), .grad_tag(grad_tag),
    .grad_quotient(grad_quotient), .grad_remainder(grad_remainder)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int ref_q(input int a, input int b);
    return (b == 0) ? 255 : a / b;
  endfunction
  function automatic int ref_r(input int a, input int b);
    return (b == 0) ? a : a % b;
  endfunction

  // port monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(disp_ready == (outstanding < 8), "R3 ready", int'(disp_ready), int'(outstanding < 8));
      if (outstanding == 8) saw_full = 1;
      if (grad_valid) begin
        if (outstanding == 0) begin
          check(0, "R5 graduation while empty", 1, 0);
        end else begin
          check(grad_tag == 3'(head_i % 8), "R5 tag", int'(grad_tag), head_i % 8);
          if (exp_b[head_i % 4096] == 0) begin
            check(grad_quotient == 8'hFF, "R7 quotient", int'(grad_quotient), 255);
            check(grad_remainder == exp_a[head_i % 4096], "R7 remainder",
                  int'(grad_remainder), int'(exp_a[head_i % 4096]));
          end else begin
            check(int'(grad_quotient) == ref_q(exp_a[head_i % 4096], exp_b[head_i % 4096]),
                  "R4 quotient", int'(grad_quotient),
                  ref_q(exp_a[head_i % 4096], exp_b[head_i % 4096]));
            check(int'(grad_remainder) == ref_r(exp_a[head_i % 4096], exp_b[head_i % 4096]),
                  "R4 remainder", int'(grad_remainder),
                  ref_r(exp_a[head_i % 4096], exp_b[head_i % 4096]));
          end
          head_i++;
        end
      end
      if (disp_valid && disp_ready) begin
        check(disp_tag == 3'(tail_i % 8), "R2 tag", int'(disp_tag), tail_i % 8);
        exp_a[tail_i % 4096] = disp_dividend;
        exp_b[tail_i % 4096] = disp_divisor;
        tail_i++;
      end
      outstanding = tail_i - head_i;
      if (outstanding > max_out) max_out = outstanding;
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      check(0, "watchdog", cyc, 150000);
      finish_run();
    end
  end

  task automatic send(input int a, input int b);
    disp_valid    = 1'b1;
    disp_dividend = 8'(a);
    disp_divisor  = 8'(b);
    do @(negedge clk); while (!disp_ready);
    @(posedge clk);
    #2;
    disp_valid = 1'b0;
  endtask

  task automatic drain();
    while (outstanding != 0) @(negedge clk);
    @(posedge clk);
    #2;
  endtask

  initial begin
    rst_n         = 1'b0;
    disp_valid    = 1'b0;
    disp_dividend = '0;
    disp_divisor  = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(disp_ready == 1'b1, "R1 ready", int'(disp_ready), 1);
    check(grad_valid == 1'b0, "R1 grad_valid", int'(grad_valid), 0);
    check(disp_tag == 3'd0, "R1 tag", int'(disp_tag), 0);
    @(posedge clk);
    #2;

    // R2: 32 pairs wrap tags four times
    for (int i = 0; i < 32; i++) send((i * 37 + 3) % 256, (i % 5) + 1);
    drain();
    @(negedge clk);
    check(disp_tag == 3'd0, "R2 wrap to zero", int'(disp_tag), 0);
    check(head_i == 32, "R5 all graduated", head_i, 32);
    @(posedge clk);
    #2;

    // R3/R6: slow head with quick followers fills the buffer
    send(255, 1);
    for (int i = 0; i < 11; i++) send(i * 20, 255);
    drain();
    check(saw_full, "R3 buffer reached full", int'(saw_full), 1);
    check(max_out > 4, "R6 more than four outstanding", max_out, 5);

    // R6/R7: alternating slow and fast, with division by zero
    send(200, 1); send(5, 7); send(128, 2); send(0, 3);
    send(9, 0); send(255, 255); send(170, 1); send(77, 0);
    send(1, 1); send(254, 3);
    drain();

    // R4/R7 sweep over every dividend with a set of divisors
    for (int j = 0; j < 8; j++) begin
      int b;
      case (j)
        0: b = 0;   1: b = 1;  2: b = 2;   3: b = 3;
        4: b = 5;   5: b = 16; 6: b = 100; default: b = 255;
      endcase
      for (int a = 0; a < 256; a++) send(a, b);
    end
    drain();
    check(head_i == tail_i, "R5 graduated equals dispatched", head_i, tail_i);
    finish_run();
  end
endmodule